// File: doc/BRIEF.md
# Audio Slot Transmit Serializer

This block turns parallel audio samples into a serial bit stream on one data line, slot by slot. A frame timing generator elsewhere supplies a bit strobe together with markers for the first bit of every slot and of every frame. The serializer decides, at each slot start, where that slot's word comes from: the sample source, its own per-slot history, or a constant zero. It then sends the word one bit per strobe, in either bit order. Samples enter through a ready/valid interface. They are right-aligned in the input word, and the configured data size may be shorter than the slot.

Three cases change how the data source is chosen. In a two-slot frame, mono mode copies the slot 0 sample into slot 1. Mute mode either replays the previous frame's values or sends silence, depending on the slot count. When a slot needs a sample and none is available, the slot goes out as zeros and a sticky underrun flag is raised. A line-release option lets the output enable drop for the whole of each masked-off slot.

Top module: `aud_slot_ser`

## Requirements
- R1: While reset is held, and on the first cycle after it, `sd_o`, `sd_oe`, `underrun` and `in_ready` are 0.
- R2: With `cfg_lsb_first` = 0, the data bits of a slot are sent most significant first, starting at bit `cfg_data_bits`-1 of the right-aligned sample.
- R3: With `cfg_lsb_first` = 1, the data bits are sent starting at bit 0 of the sample.
- R4: A slot bit whose position within the slot is `cfg_data_bits` or more is sent as 0.
- R5: `in_ready` is high only in a cycle where both `bit_en` and `slot_first` are high and the slot takes a fresh sample. Exactly one sample is taken per such handshake.
- R6: With `cfg_mono` = 1 and `cfg_slot_count` = 2, slot 1 resends the sample that slot 0 sent in the same frame, and only one sample is taken per frame.
- R7: With `cfg_mute` = 1, `cfg_mute_replay` = 1 and `cfg_slot_count` of 2 or less, each active slot resends the word it sent in the previous frame, and no sample is taken.
- R8: With `cfg_mute` = 1 and either `cfg_mute_replay` = 0 or `cfg_slot_count` above 2, every active slot sends only zeros.
- R9: When an active slot needs a sample and `in_valid` is 0, the slot is sent as zeros and `underrun` becomes 1 one cycle after that slot's first-bit strobe.
- R10: `underrun` stays at 1 until a cycle with `clr_underrun` = 1; it is 0 on the following cycle unless a new underrun occurs in that same cycle.
- R11: A slot is inactive when its bit in `cfg_slot_mask` is 0 (bit n is slot n). An inactive slot sends 0 with `sd_oe` = 0 if `cfg_tristate` = 1, and with `sd_oe` = 1 otherwise. Active slots always have `sd_oe` = 1.
- R12: `sd_o` and `sd_oe` change only on the clock edge of a cycle with `bit_en` = 1, and show that strobe's bit from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | One serial bit advances in this cycle |
| slot_first | input | 1 | With bit_en: this bit is the first of a slot |
| frame_first | input | 1 | With bit_en and slot_first: this slot is slot 0 |
| in_data | input | SAMPLE_W | Right-aligned sample |
| in_valid | input | 1 | A sample is available |
| in_ready | output | 1 | The sample is taken in this cycle |
| cfg_lsb_first | input | 1 | 1 = least significant bit first |
| cfg_data_bits | input | DB_W | Data bits per slot |
| cfg_slot_count | input | NS_W | Slots per frame |
| cfg_slot_mask | input | MAX_SLOTS | Active-slot mask, bit n = slot n |
| cfg_mono | input | 1 | Mono duplication |
| cfg_mute | input | 1 | Mute |
| cfg_mute_replay | input | 1 | Mute replays the previous frame |
| cfg_tristate | input | 1 | Release the line in inactive slots |
| clr_underrun | input | 1 | Clears the underrun flag |
| underrun | output | 1 | Sticky underrun flag |
| sd_o | output | 1 | Serial data |
| sd_oe | output | 1 | Serial data output enable |

## Verification
The bench runs a sequence of frame configurations and keeps them in order, so that mute replay is tested against history that mono frames wrote earlier. A design that replays from the wrong slot, or that refreshes its history while muted, sends the wrong words. Partial data sizes and both bit orders catch an off-by-one in the bit index, which would leak stray bits into the zero-padded tail. The bench counts samples taken against samples expected in the mono, mute and masked-slot cases, so a design that pulls samples during those slots fails. An input-starved slot, a long stretch without a clear, a clear pulse, and a stall in the middle of a slot check that the flag is sticky and that the output holds while no strobe arrives.

// File: rtl/aud_ser_pkg.sv
package aud_ser_pkg;

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_FIFO = 2'd1,
        SRC_HIST = 2'd2,
        SRC_ZERO = 2'd3
    } word_src_e;

    typedef struct packed {
        word_src_e src;
        logic      active;
        logic      mono_copy;
    } slot_plan_t;

    function automatic logic replay_allowed(input logic rep, input int unsigned nslots);
        return rep && (nslots <= 2);
    endfunction

endpackage

// File: rtl/aud_slot_plan.sv
module aud_slot_plan
    import aud_ser_pkg::*;
#(
    parameter int MAX_SLOTS = 4,
    localparam int SI_W = (MAX_SLOTS > 1) ? $clog2(MAX_SLOTS) : 1,
    localparam int NS_W = $clog2(MAX_SLOTS + 1)
) (
    input  logic [SI_W-1:0]      slot,
    input  logic [NS_W-1:0]      slot_count,
    input  logic [MAX_SLOTS-1:0] slot_mask,
    input  logic                 mono,
    input  logic                 mute,
    input  logic                 mute_replay,
    output slot_plan_t           plan
);
    logic in_range;

    always_comb begin
        in_range       = NS_W'(slot) < slot_count;
        plan.active    = in_range && slot_mask[slot];
        plan.mono_copy = 1'b0;
        plan.src       = SRC_NONE;
        if (plan.active) begin
            if (mute) begin
                plan.src = replay_allowed(mute_replay, int'(slot_count)) ? SRC_HIST : SRC_ZERO;
            end else if (mono && slot_count == NS_W'(2) && slot == SI_W'(1)) begin
                plan.src       = SRC_HIST;
                plan.mono_copy = 1'b1;
            end else begin
                plan.src = SRC_FIFO;
            end
        end
    end
endmodule

// File: rtl/aud_slot_hist.sv
module aud_slot_hist #(
    parameter int SAMPLE_W  = 16,
    parameter int MAX_SLOTS = 4,
    localparam int SI_W = (MAX_SLOTS > 1) ? $clog2(MAX_SLOTS) : 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [SI_W-1:0]     wr_idx,
    input  logic [SAMPLE_W-1:0] wr_data,
    input  logic [SI_W-1:0]     rd_idx,
    output logic [SAMPLE_W-1:0] rd_data
);
    logic [SAMPLE_W-1:0] words [MAX_SLOTS];

    for (genvar g = 0; g < MAX_SLOTS; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)
                words[g] <= '0;
            else if (wr_en && wr_idx == SI_W'(g))
                words[g] <= wr_data;
        end
    end

    assign rd_data = words[rd_idx];
endmodule

// File: rtl/aud_bit_out.sv
module aud_bit_out #(
    parameter int SAMPLE_W = 16,
    localparam int DB_W = $clog2(SAMPLE_W + 1)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bit_en,
    input  logic                load,
    input  logic [SAMPLE_W-1:0] load_word,
    input  logic                load_active,
    input  logic                lsb_first,
    input  logic [DB_W-1:0]     data_bits,
    input  logic                tristate,
    output logic                sd_o,
    output logic                sd_oe
);
    logic [SAMPLE_W-1:0] word_q, nxt_word, shifted;
    logic [DB_W-1:0]     pos_q, nxt_pos, idx;
    logic                act_q, nxt_act, nxt_bit;

    always_comb begin
        nxt_word = load ? load_word : word_q;
        nxt_act  = load ? load_active : act_q;
        if (load)
            nxt_pos = '0;
        else if (pos_q == {DB_W{1'b1}})
            nxt_pos = pos_q;
        else
            nxt_pos = pos_q + DB_W'(1);
        idx     = lsb_first ? nxt_pos : (data_bits - DB_W'(1) - nxt_pos);
        shifted = nxt_word >> idx;
        nxt_bit = nxt_act && (nxt_pos < data_bits) && shifted[0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= '0;
            pos_q  <= '0;
            act_q  <= 1'b0;
            sd_o   <= 1'b0;
            sd_oe  <= 1'b0;
        end else if (bit_en) begin
            word_q <= nxt_word;
            pos_q  <= nxt_pos;
            act_q  <= nxt_act;
            sd_o   <= nxt_bit;
            sd_oe  <= nxt_act || !tristate;
        end
    end
endmodule

// File: rtl/aud_slot_ser.sv
module aud_slot_ser
    import aud_ser_pkg::*;
#(
    parameter int SAMPLE_W  = 16,
    parameter int MAX_SLOTS = 4,
    localparam int SI_W = (MAX_SLOTS > 1) ? $clog2(MAX_SLOTS) : 1,
    localparam int NS_W = $clog2(MAX_SLOTS + 1),
    localparam int DB_W = $clog2(SAMPLE_W + 1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bit_en,
    input  logic                 slot_first,
    input  logic                 frame_first,
    input  logic [SAMPLE_W-1:0]  in_data,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic                 cfg_lsb_first,
    input  logic [DB_W-1:0]      cfg_data_bits,
    input  logic [NS_W-1:0]      cfg_slot_count,
    input  logic [MAX_SLOTS-1:0] cfg_slot_mask,
    input  logic                 cfg_mono,
    input  logic                 cfg_mute,
    input  logic                 cfg_mute_replay,
    input  logic                 cfg_tristate,
    input  logic                 clr_underrun,
    output logic                 underrun,
    output logic                 sd_o,
    output logic                 sd_oe
);
    logic                slot_start;
    logic [SI_W-1:0]     slot_q, cur_slot, hist_rd_idx;
    slot_plan_t          plan;
    logic [SAMPLE_W-1:0] hist_word, slot_word;
    logic                starved;

    assign slot_start = bit_en && slot_first;

    always_comb begin
        if (frame_first)
            cur_slot = '0;
        else if (slot_q == SI_W'(MAX_SLOTS - 1))
            cur_slot = slot_q;
        else
            cur_slot = slot_q + SI_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst)
            slot_q <= '0;
        else if (slot_start)
            slot_q <= cur_slot;
    end

    aud_slot_plan #(.MAX_SLOTS(MAX_SLOTS)) u_plan (
        .slot        (cur_slot),
        .slot_count  (cfg_slot_count),
        .slot_mask   (cfg_slot_mask),
        .mono        (cfg_mono),
        .mute        (cfg_mute),
        .mute_replay (cfg_mute_replay),
        .plan        (plan)
    );

    assign hist_rd_idx = plan.mono_copy ? '0 : cur_slot;

    always_comb begin
        unique case (plan.src)
            SRC_FIFO: slot_word = in_valid ? in_data : '0;
            SRC_HIST: slot_word = hist_word;
            default:  slot_word = '0;
        endcase
    end

    assign in_ready = slot_start && (plan.src == SRC_FIFO);
    assign starved  = in_ready && !in_valid;

    aud_slot_hist #(.SAMPLE_W(SAMPLE_W), .MAX_SLOTS(MAX_SLOTS)) u_hist (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (slot_start && plan.active),
        .wr_idx  (cur_slot),
        .wr_data (slot_word),
        .rd_idx  (hist_rd_idx),
        .rd_data (hist_word)
    );

    always_ff @(posedge clk) begin
        if (rst)
            underrun <= 1'b0;
        else if (starved)
            underrun <= 1'b1;
        else if (clr_underrun)
            underrun <= 1'b0;
    end

    aud_bit_out #(.SAMPLE_W(SAMPLE_W)) u_out (
        .clk         (clk),
        .rst         (rst),
        .bit_en      (bit_en),
        .load        (slot_start),
        .load_word   (slot_word),
        .load_active (plan.active),
        .lsb_first   (cfg_lsb_first),
        .data_bits   (cfg_data_bits),
        .tristate    (cfg_tristate),
        .sd_o        (sd_o),
        .sd_oe       (sd_oe)
    );
endmodule

// File: rtl/aud_slot_ser_chk.sv
module aud_slot_ser_chk (
    input logic clk,
    input logic rst,
    input logic bit_en,
    input logic slot_first,
    input logic in_valid,
    input logic in_ready,
    input logic cfg_mute,
    input logic clr_underrun,
    input logic underrun,
    input logic sd_o,
    input logic sd_oe
);
    p_ready_at_slot_start_r5: assert property (@(posedge clk) disable iff (rst)
        in_ready |-> (bit_en && slot_first));

    p_mute_takes_nothing_r7: assert property (@(posedge clk) disable iff (rst)
        cfg_mute |-> !in_ready);

    p_underrun_cause_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(underrun) |-> $past(bit_en && slot_first && !in_valid));

    p_underrun_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        (underrun && !clr_underrun) |=> underrun);

    p_released_line_low_r11: assert property (@(posedge clk) disable iff (rst)
        !sd_oe |-> !sd_o);

    p_hold_without_strobe_r12: assert property (@(posedge clk) disable iff (rst)
        !bit_en |=> ($stable(sd_o) && $stable(sd_oe)));
endmodule

bind aud_slot_ser aud_slot_ser_chk u_chk (.*);

// File: tb/sim_aud_slot_ser.sv
module sim_aud_slot_ser;
    localparam int SW = 16;
    localparam int SLOT_LEN = 16;

    typedef struct packed {
        logic       lsb;
        logic [4:0] dbits;
        logic [2:0] nslots;
        logic [3:0] mask;
        logic       mono;
        logic       mute;
        logic       rep;
        logic       trs;
        logic [3:0] nsamp;
        logic [1:0] frames;
    } row_t;

    localparam int NROWS = 10;
    localparam row_t ROWS [NROWS] = '{
        '{1'b0, 5'd16, 3'd2, 4'b0011, 1'b0, 1'b0, 1'b0, 1'b0, 4'd6, 2'd3},
        '{1'b1, 5'd16, 3'd2, 4'b0011, 1'b0, 1'b0, 1'b0, 1'b0, 4'd4, 2'd2},
        '{1'b0, 5'd12, 3'd4, 4'b1111, 1'b0, 1'b0, 1'b0, 1'b0, 4'd8, 2'd2},
        '{1'b1, 5'd10, 3'd4, 4'b0101, 1'b0, 1'b0, 1'b0, 1'b1, 4'd4, 2'd2},
        '{1'b0, 5'd16, 3'd4, 4'b1011, 1'b0, 1'b0, 1'b0, 1'b0, 4'd6, 2'd2},
        '{1'b0, 5'd16, 3'd2, 4'b0011, 1'b1, 1'b0, 1'b0, 1'b0, 4'd2, 2'd2},
        '{1'b0, 5'd16, 3'd2, 4'b0011, 1'b0, 1'b1, 1'b1, 1'b0, 4'd0, 2'd2},
        '{1'b1, 5'd16, 3'd4, 4'b1111, 1'b0, 1'b1, 1'b1, 1'b0, 4'd0, 2'd1},
        '{1'b0, 5'd16, 3'd2, 4'b0011, 1'b0, 1'b1, 1'b0, 1'b0, 4'd0, 2'd1},
        '{1'b0, 5'd16, 3'd2, 4'b0011, 1'b0, 1'b0, 1'b0, 1'b0, 4'd1, 2'd1}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bit_en = 1'b0, slot_first = 1'b0, frame_first = 1'b0;
    logic [SW-1:0] in_data = '0;
    logic in_valid = 1'b0;
    logic in_ready;
    logic cfg_lsb_first = 1'b0;
    logic [4:0] cfg_data_bits = 5'd16;
    logic [2:0] cfg_slot_count = 3'd2;
    logic [3:0] cfg_slot_mask = 4'b0011;
    logic cfg_mono = 1'b0, cfg_mute = 1'b0, cfg_mute_replay = 1'b0, cfg_tristate = 1'b0;
    logic clr_underrun = 1'b0;
    logic underrun, sd_o, sd_oe;

    always #2 clk = ~clk;

    aud_slot_ser #(.SAMPLE_W(SW), .MAX_SLOTS(4)) u0 (.*);

    int n_chk = 0, n_bad = 0, cyc = 0;
    logic finished = 1'b0;
    logic [SW-1:0] q [$];
    logic [SW-1:0] mh [4];
    logic munder = 1'b0;
    int seed = 0;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_bit(input logic sf, input logic ff, output logic b, output logic oe, output logic popped);
        bit_en = 1'b1; slot_first = sf; frame_first = ff;
        in_valid = (q.size() != 0);
        in_data = in_valid ? q[0] : '0;
        #1;
        popped = in_ready && in_valid;
        @(posedge clk);
        if (popped) void'(q.pop_front());
        @(negedge clk);
        b = sd_o; oe = sd_oe;
        bit_en = 1'b0; slot_first = 1'b0; frame_first = 1'b0;
    endtask

    task automatic run_slot(input int s);
        logic active, need_pop, exp_pop, b, oe, popped, any_pop, oe_ok;
        logic [SW-1:0] word;
        logic [SLOT_LEN-1:0] exp_bits, act_bits;
        string tag;
        active = cfg_slot_mask[s];
        need_pop = 1'b0;
        word = '0;
        if (!active) tag = "R11";
        else if (cfg_mute) begin
            if (cfg_mute_replay && cfg_slot_count <= 2) begin word = mh[s]; tag = "R7"; end
            else tag = "R8";
        end else if (cfg_mono && cfg_slot_count == 2 && s == 1) begin
            word = mh[0]; tag = "R6";
        end else begin
            need_pop = 1'b1;
            if (q.size() != 0) begin
                word = q[0];
                if (cfg_lsb_first) tag = "R3";
                else if (cfg_data_bits < 16) tag = "R4";
                else tag = "R2";
            end else begin
                munder = 1'b1; tag = "R9";
            end
        end
        exp_pop = need_pop && (q.size() != 0);
        if (active) mh[s] = word;
        for (int p = 0; p < SLOT_LEN; p++) begin
            if (p < int'(cfg_data_bits))
                exp_bits[p] = cfg_lsb_first ? word[p] : word[int'(cfg_data_bits) - 1 - p];
            else
                exp_bits[p] = 1'b0;
        end
        any_pop = 1'b0; oe_ok = 1'b1;
        for (int p = 0; p < SLOT_LEN; p++) begin
            do_bit(p == 0, (p == 0) && (s == 0), b, oe, popped);
            act_bits[p] = b;
            if (oe !== (active || !cfg_tristate)) oe_ok = 1'b0;
            if (popped) any_pop = 1'b1;
        end
        check(tag, {16'd0, act_bits}, {16'd0, exp_bits});
        check("R11", {31'd0, oe_ok}, 32'd1);
        check("R5", {31'd0, any_pop}, {31'd0, exp_pop});
    endtask

    initial begin : watchdog
        while (!finished) begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                n_bad++; n_chk++;
                $display("FAIL watchdog actual=%0d expected<150000", cyc);
                $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
                $finish;
            end
        end
    end

    initial begin : main
        logic b, oe, popped;
        for (int i = 0; i < 4; i++) mh[i] = '0;
        repeat (3) @(negedge clk);
        check("R1", {28'd0, sd_o, sd_oe, underrun, in_ready}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R1", {28'd0, sd_o, sd_oe, underrun, in_ready}, 32'd0);

        for (int r = 0; r < NROWS; r++) begin
            cfg_lsb_first = ROWS[r].lsb;
            cfg_data_bits = ROWS[r].dbits;
            cfg_slot_count = ROWS[r].nslots;
            cfg_slot_mask = ROWS[r].mask;
            cfg_mono = ROWS[r].mono;
            cfg_mute = ROWS[r].mute;
            cfg_mute_replay = ROWS[r].rep;
            cfg_tristate = ROWS[r].trs;
            for (int k = 0; k < int'(ROWS[r].nsamp); k++) begin
                seed++;
                q.push_back(16'hA5C3 ^ SW'(seed * 16'h1357));
            end
            for (int f = 0; f < int'(ROWS[r].frames); f++)
                for (int s = 0; s < int'(ROWS[r].nslots); s++)
                    run_slot(s);
            check("R5", q.size(), 32'd0);
            check("R9", {31'd0, underrun}, {31'd0, munder});
        end

        // R10: flag holds without a clear, then a single clear pulse drops it
        repeat (5) @(negedge clk);
        check("R10", {31'd0, underrun}, 32'd1);
        clr_underrun = 1'b1;
        @(negedge clk);
        clr_underrun = 1'b0;
        check("R10", {31'd0, underrun}, 32'd0);

        // R12: a stall mid-slot holds the line; in_ready stays low without a slot start
        cfg_lsb_first = 1'b0; cfg_data_bits = 5'd16; cfg_slot_count = 3'd2;
        cfg_slot_mask = 4'b0011; cfg_mono = 1'b0; cfg_mute = 1'b0;
        q.push_back(16'h8000);
        do_bit(1'b1, 1'b1, b, oe, popped);
        check("R12", {31'd0, b}, 32'd1);
        q.push_back(16'h1234);
        in_valid = 1'b1; in_data = 16'h1234;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check("R12", {31'd0, sd_o}, 32'd1);
            check("R5", {31'd0, in_ready}, 32'd0);
        end
        do_bit(1'b0, 1'b0, b, oe, popped);
        check("R12", {31'd0, b}, 32'd0);
        check("R5", {31'd0, popped}, 32'd0);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule